// File: doc/BRIEF.md
# Speed-Ranked Flash Block Allocator

This block picks an erase block for each write sub-request aimed at one flash chip. It keeps, for every chip, a valid flag and a program-speed class for every block. Together these place the chip's blocks in a speed order. Within one class, a larger block index counts as faster. A request whose chip is congested gets the fastest valid block. Any other request gets the slowest valid block. A write that spans several chips is split upstream, and each per-chip piece is presented as its own request.

The table is changed by update commands, one per cycle:
- A full command makes a block unusable.
- An erase command makes the block usable again and leaves its rank as it was.
- A slow-down command moves a block one class toward the slow end.

Allocation lookups read the table and never change it. When an allocation request is present, the update port is not ready, so allocation wins any collision.

Top module: `flash_speed_alloc`

## Requirements
- R1: After reset every block of every chip is valid and in the fastest class (class NCLS-1). Both allocation outputs are low, and `upd_ready_o` is high while no allocation is requested.
- R2: A request sampled at a rising edge produces, at that same edge, exactly one of `alloc_valid_o` and `alloc_none_o`, held for one cycle. In cycles without a request, both stay low.
- R3: When `alloc_pend_i` is greater than 1, the result is the valid block with the highest class. Among blocks of that class, the highest index is chosen.
- R4: When `alloc_pend_i` is 0 or 1, the result is the valid block with the lowest class. Among blocks of that class, the lowest index is chosen.
- R5: The full command (`upd_op_i` = 2'b00) clears the addressed block's valid flag. Allocation then skips that block.
- R6: The erase command (`upd_op_i` = 2'b01) sets the addressed block valid again and leaves its class unchanged.
- R7: The slow-down command (`upd_op_i` = 2'b10) lowers the addressed block's class by one, stopping at class 0 (slowest). The class of a block never rises. Code 2'b11 changes nothing.
- R8: When no block of the requested chip is valid, `alloc_none_o` is raised and `alloc_blk_o` is 0.
- R9: An update to one chip leaves every other chip's blocks unchanged.
- R10: While `alloc_req_i` is high, `upd_ready_o` is low. An update presented in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req_i | input | 1 | Allocation request |
| alloc_chip_i | input | CHIP_W | Target chip of the request |
| alloc_pend_i | input | PEND_W | Pending-request count of the target chip |
| upd_valid_i | input | 1 | Update command present |
| upd_op_i | input | 2 | 00 full, 01 erased, 10 slow down, 11 none |
| upd_chip_i | input | CHIP_W | Chip addressed by the update |
| upd_blk_i | input | BLK_W | Block addressed by the update |
| upd_ready_o | output | 1 | Update accepted this cycle |
| alloc_valid_o | output | 1 | Block chosen |
| alloc_blk_o | output | BLK_W | Chosen block index |
| alloc_none_o | output | 1 | Chip has no valid block |

## Verification
Several properties are checked on every cycle:
- Each request gets exactly one response, and idle cycles get none.
- No block's class ever rises.
- A full command always leaves its block invalid.
- An erase command always leaves its block valid at its former class.
- A no-free-block result always carries index 0.

Whether the chosen index is truly the fastest or slowest valid block shows only in the bench's scenarios. The same holds for saturation at the slow end, chip independence, and updates blocked by a colliding request. The bench compares against a reference model of the table in directed and random sequences.

// File: rtl/flash_alloc_pkg.sv
`timescale 1ns/1ps
package flash_alloc_pkg;
   typedef enum logic [1:0] {
      OP_FULL   = 2'b00,
      OP_ERASE  = 2'b01,
      OP_SLOWER = 2'b10,
      OP_NOP    = 2'b11
   } upd_op_e;
endpackage

// File: rtl/flash_blk_table.sv
`timescale 1ns/1ps
module flash_blk_table
   import flash_alloc_pkg::*;
#(
   parameter int NCHIP = 4,
   parameter int NBLK  = 8,
   parameter int NCLS  = 3,
   localparam int CHIP_W = (NCHIP > 1) ? $clog2(NCHIP) : 1,
   localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1,
   localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en_i,
   input  upd_op_e                         wr_op_i,
   input  logic [CHIP_W-1:0]               wr_chip_i,
   input  logic [BLK_W-1:0]                wr_blk_i,
   input  logic [CHIP_W-1:0]               rd_chip_i,
   output logic [NBLK-1:0]                 rd_vld_o,
   output logic [NBLK-1:0][CLS_W-1:0]      rd_cls_o
);
   localparam logic [CLS_W-1:0] CLS_FAST = CLS_W'(NCLS - 1);

   logic [NCHIP-1:0][NBLK-1:0]             vld_q;
   logic [NCHIP-1:0][NBLK-1:0][CLS_W-1:0]  cls_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCHIP; c++) begin
            for (int b = 0; b < NBLK; b++) begin
               vld_q[c][b] <= 1'b1;
               cls_q[c][b] <= CLS_FAST;
            end
         end
      end else if (wr_en_i) begin
         unique case (wr_op_i)
            OP_FULL:   vld_q[wr_chip_i][wr_blk_i] <= 1'b0;
            OP_ERASE:  vld_q[wr_chip_i][wr_blk_i] <= 1'b1;
            OP_SLOWER: begin
               if (cls_q[wr_chip_i][wr_blk_i] != '0)
                  cls_q[wr_chip_i][wr_blk_i] <= cls_q[wr_chip_i][wr_blk_i] - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign rd_vld_o = vld_q[rd_chip_i];
   assign rd_cls_o = cls_q[rd_chip_i];

   for (genvar c = 0; c < NCHIP; c++) begin : g_chip_chk
      for (genvar b = 0; b < NBLK; b++) begin : g_blk_chk
         // R7
         cls_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cls_q[c][b] <= $past(cls_q[c][b]));
         // R5
         full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_op_i == OP_FULL && wr_chip_i == CHIP_W'(c) && wr_blk_i == BLK_W'(b))
            |=> !vld_q[c][b]);
         // R6
         erase_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_op_i == OP_ERASE && wr_chip_i == CHIP_W'(c) && wr_blk_i == BLK_W'(b))
            |=> (vld_q[c][b] && cls_q[c][b] == $past(cls_q[c][b])));
      end
   end
endmodule

// File: rtl/flash_blk_pick.sv
`timescale 1ns/1ps
module flash_blk_pick #(
   parameter int NBLK = 8,
   parameter int NCLS = 3,
   localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1,
   localparam int CLS_W = (NCLS > 1) ? $clog2(NCLS) : 1
) (
   input  logic [NBLK-1:0]             vld_i,
   input  logic [NBLK-1:0][CLS_W-1:0]  cls_i,
   input  logic                        fast_i,
   output logic                        found_o,
   output logic [BLK_W-1:0]            idx_o
);
   logic [CLS_W-1:0] best_cls;

   always_comb begin
      found_o  = 1'b0;
      idx_o    = '0;
      best_cls = '0;
      for (int i = 0; i < NBLK; i++) begin
         if (vld_i[i]) begin
            if (!found_o
                || ( fast_i && cls_i[i] >= best_cls)
                || (!fast_i && cls_i[i] <  best_cls)) begin
               found_o  = 1'b1;
               idx_o    = BLK_W'(i);
               best_cls = cls_i[i];
            end
         end
      end
   end
endmodule

// File: rtl/flash_speed_alloc.sv
`timescale 1ns/1ps
module flash_speed_alloc
   import flash_alloc_pkg::*;
#(
   parameter int NCHIP  = 4,
   parameter int NBLK   = 8,
   parameter int NCLS   = 3,
   parameter int PEND_W = 4,
   localparam int CHIP_W = (NCHIP > 1) ? $clog2(NCHIP) : 1,
   localparam int BLK_W  = (NBLK > 1) ? $clog2(NBLK) : 1,
   localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req_i,
   input  logic [CHIP_W-1:0] alloc_chip_i,
   input  logic [PEND_W-1:0] alloc_pend_i,
   input  logic              upd_valid_i,
   input  logic [1:0]        upd_op_i,
   input  logic [CHIP_W-1:0] upd_chip_i,
   input  logic [BLK_W-1:0]  upd_blk_i,
   output logic              upd_ready_o,
   output logic              alloc_valid_o,
   output logic [BLK_W-1:0]  alloc_blk_o,
   output logic              alloc_none_o
);
   if (NCHIP < 1 || (1 << CHIP_W) != NCHIP && NCHIP > 1) begin : g_bad_chip
      $error("NCHIP must be a power of two");
   end
   if (NBLK < 2 || (1 << BLK_W) != NBLK) begin : g_bad_blk
      $error("NBLK must be a power of two of at least 2");
   end
   if (NCLS < 2) begin : g_bad_cls
      $error("NCLS must be at least 2");
   end
   if (PEND_W < 2) begin : g_bad_pend
      $error("PEND_W must be at least 2");
   end

   logic                       wr_en;
   logic                       congested;
   logic [NBLK-1:0]            rd_vld;
   logic [NBLK-1:0][CLS_W-1:0] rd_cls;
   logic                       pick_found;
   logic [BLK_W-1:0]           pick_idx;

   assign upd_ready_o = !alloc_req_i;
   assign wr_en       = upd_valid_i && upd_ready_o;
   assign congested   = alloc_pend_i > PEND_W'(1);

   flash_blk_table #(.NCHIP(NCHIP), .NBLK(NBLK), .NCLS(NCLS)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_op_i   (upd_op_e'(upd_op_i)),
      .wr_chip_i (upd_chip_i),
      .wr_blk_i  (upd_blk_i),
      .rd_chip_i (alloc_chip_i),
      .rd_vld_o  (rd_vld),
      .rd_cls_o  (rd_cls)
   );

   flash_blk_pick #(.NBLK(NBLK), .NCLS(NCLS)) u_pick (
      .vld_i   (rd_vld),
      .cls_i   (rd_cls),
      .fast_i  (congested),
      .found_o (pick_found),
      .idx_o   (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alloc_valid_o <= 1'b0;
         alloc_none_o  <= 1'b0;
         alloc_blk_o   <= '0;
      end else begin
         alloc_valid_o <= alloc_req_i && pick_found;
         alloc_none_o  <= alloc_req_i && !pick_found;
         alloc_blk_o   <= (alloc_req_i && pick_found) ? pick_idx : '0;
      end
   end

   // R2
   resp_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_req_i |=> (alloc_valid_o != alloc_none_o));
   // R2
   resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc_req_i |=> (!alloc_valid_o && !alloc_none_o));
   // R8
   none_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_none_o |-> (alloc_blk_o == '0));
endmodule

// File: tb/flash_speed_alloc_test.sv
`timescale 1ns/1ps
module flash_speed_alloc_test;
   localparam int NCH = 4;
   localparam int NB  = 8;
   localparam int NC  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alloc_req = 1'b0;
   logic [1:0] alloc_chip = '0;
   logic [3:0] alloc_pend = '0;
   logic       upd_valid = 1'b0;
   logic [1:0] upd_op = 2'b11;
   logic [1:0] upd_chip = '0;
   logic [2:0] upd_blk = '0;
   logic       upd_ready;
   logic       alloc_valid;
   logic [2:0] alloc_blk;
   logic       alloc_none;

   int checks = 0;
   int failures = 0;
   bit mvld [NCH][NB];
   int mcls [NCH][NB];

   always #2.5 clk = ~clk;

   flash_speed_alloc #(.NCHIP(NCH), .NBLK(NB), .NCLS(NC), .PEND_W(4)) uut (
      .clk(clk), .rst_n(rst_n),
      .alloc_req_i(alloc_req), .alloc_chip_i(alloc_chip), .alloc_pend_i(alloc_pend),
      .upd_valid_i(upd_valid), .upd_op_i(upd_op), .upd_chip_i(upd_chip), .upd_blk_i(upd_blk),
      .upd_ready_o(upd_ready), .alloc_valid_o(alloc_valid), .alloc_blk_o(alloc_blk),
      .alloc_none_o(alloc_none)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic void exp_pick(input int ch, input bit fast, output bit fnd, output int idx);
      int bc;
      fnd = 0; idx = 0; bc = 0;
      for (int i = 0; i < NB; i++) begin
         if (mvld[ch][i]) begin
            if (!fnd || (fast && mcls[ch][i] >= bc) || (!fast && mcls[ch][i] < bc)) begin
               fnd = 1; idx = i; bc = mcls[ch][i];
            end
         end
      end
   endfunction

   // encoded result: valid*512 + none*256 + index
   task automatic step(input bit a, input int ch, input int pend, input bit u,
                       input int op, input int uch, input int ub, input string tag);
      bit fnd;
      int idx;
      int act;
      int exp;
      @(negedge clk);
      alloc_req = a; alloc_chip = 2'(ch); alloc_pend = 4'(pend);
      upd_valid = u; upd_op = 2'(op); upd_chip = 2'(uch); upd_blk = 3'(ub);
      #1;
      // R10: ready falls while a request is present
      chk(upd_ready == !a, "R10", int'(upd_ready), int'(!a));
      exp_pick(ch, pend > 1, fnd, idx);
      @(posedge clk);
      if (u && !a) begin
         case (op)
            0: mvld[uch][ub] = 0;
            1: mvld[uch][ub] = 1;
            2: if (mcls[uch][ub] > 0) mcls[uch][ub]--;
            default: ;
         endcase
      end
      @(negedge clk);
      act = int'(alloc_valid) * 512 + int'(alloc_none) * 256 + int'(alloc_blk);
      if (a) begin
         exp = fnd ? (512 + idx) : 256;
         chk(act == exp, tag, act, exp);
      end else begin
         // R2: no response without a request
         chk(act == 0, "R2", act, 0);
      end
      alloc_req = 0; upd_valid = 0; upd_op = 2'b11;
   endtask

   initial begin
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd2024);
      for (int c = 0; c < NCH; c++)
         for (int b = 0; b < NB; b++) begin
            mvld[c][b] = 1; mcls[c][b] = NC - 1;
         end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs and ready after reset
      chk(!alloc_valid && !alloc_none && upd_ready, "R1",
          int'(alloc_valid) * 4 + int'(alloc_none) * 2 + int'(upd_ready), 1);

      // R1: all fast: slow pick = 0, fast pick = 7
      step(1, 0, 0, 0, 3, 0, 0, "R1");
      step(1, 0, 3, 0, 3, 0, 0, "R1");
      // R4 boundary: pend 1 is not congested
      step(1, 0, 1, 0, 3, 0, 0, "R4");
      // R3 boundary: pend 2 is congested
      step(1, 0, 2, 0, 3, 0, 0, "R3");
      // R5: full block 0 then slow pick 1
      step(0, 0, 0, 1, 0, 0, 0, "R5");
      step(1, 0, 0, 0, 3, 0, 0, "R5");
      // R7: slow down block 3 twice, then once more to saturate
      step(0, 0, 0, 1, 2, 0, 3, "R7");
      step(1, 0, 0, 0, 3, 0, 0, "R7");
      step(0, 0, 0, 1, 2, 0, 3, "R7");
      step(0, 0, 0, 1, 2, 0, 3, "R7");
      step(1, 0, 0, 0, 3, 0, 0, "R7");
      // R7: slow down block 5 once: fast pick stays 7 in top class
      step(0, 0, 0, 1, 2, 0, 5, "R7");
      step(1, 0, 3, 0, 3, 0, 0, "R3");
      // R3: full block 7, fast pick 6
      step(0, 0, 0, 1, 0, 0, 7, "R3");
      step(1, 0, 3, 0, 3, 0, 0, "R3");
      // R6: full then erase block 3 keeps slowest rank
      step(0, 0, 0, 1, 0, 0, 3, "R6");
      step(1, 0, 0, 0, 3, 0, 0, "R6");
      step(0, 0, 0, 1, 1, 0, 3, "R6");
      step(1, 0, 0, 0, 3, 0, 0, "R6");
      // R9: chip 1 untouched
      step(1, 1, 0, 0, 3, 0, 0, "R9");
      step(1, 1, 3, 0, 3, 0, 0, "R9");
      // R8: empty chip 2
      for (int b = 0; b < NB; b++) step(0, 0, 0, 1, 0, 2, b, "R8");
      step(1, 2, 0, 0, 3, 0, 0, "R8");
      step(1, 2, 3, 0, 3, 0, 0, "R8");
      // R10: colliding update is dropped
      step(1, 3, 0, 1, 0, 3, 0, "R10");
      step(1, 3, 0, 0, 3, 0, 0, "R10");
      // R7: code 3 changes nothing
      step(0, 0, 0, 1, 3, 3, 0, "R7");
      step(1, 3, 0, 0, 3, 0, 0, "R7");

      for (int n = 0; n < 600; n++) begin
         bit a;
         int pend;
         int r;
         int op;
         a = ($urandom % 3) != 0;
         pend = $urandom % 4;
         r = $urandom % 8;
         op = (r < 2) ? 0 : (r < 5) ? 1 : (r < 7) ? 2 : 3;
         step(a, $urandom % NCH, pend, $urandom % 2, op, $urandom % NCH, $urandom % NB,
              a ? ((pend > 1) ? "R3" : "R4") : "R2");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule